// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block holds the per-pin pending state of an interrupt router and decides when each input line turns into a delivery request. It samples the input line levels and tracks a pending bit for every line. It keeps a remote-acknowledge bit for level-triggered pins. It runs a storm throttle that holds back redelivery when a level source keeps firing. Per-pin configuration comes from an external register file: mask, trigger mode, vector and destination. The block also receives notices when a pin's entry was rewritten, and end-of-interrupt (EOI) broadcasts that carry a vector number.

Requests leave on a valid/ready stream. The request slot is one register deep. Once `req_valid` is high, the pin, vector, destination and trigger fields stay frozen until a cycle with `req_ready` high. A transfer happens on that cycle, and a new request can be loaded on the same edge. While the consumer holds `req_ready` low, new events keep collecting in the pending bits. When the slot frees, the eligible pin with the lowest index is sent first. The block does no destination matching.

Top module: `irq_pin_svc`

## Requirements
- R1: Reset clears the pending state, the remote-acknowledge bits, the storm counters and the delay timer. `req_valid` is low during reset and after it.
- R2: A rising line on an unmasked edge pin (`cfg_level` bit = 0) gives exactly one request. The request carries that pin's index, vector, destination and `req_level`=0. A line that stays high gives no further request, because the repeated assertion is coalesced.
- R3: A low line clears the pin's pending bit. A level pin whose line drops before its request is loaded is not delivered.
- R4: A masked pin (`cfg_mask` bit = 1) is never serviced. A level pin (`cfg_level` bit = 1) is not serviced while its remote-acknowledge bit is set. A service attempt that is refused is dropped, not queued.
- R5: Loading a request for a level pin sets that pin's remote-acknowledge bit.
- R6: An EOI clears the remote-acknowledge bit of every level pin whose vector equals the EOI vector. Each such pin that is unmasked and still has its line high is requested again. EOIs are ignored by edge pins and by pins with other vectors.
- R7: A configuration notice for a pin does two things. If the pin is now edge-triggered, its remote-acknowledge bit is cleared. If it is level-triggered, unmasked, pending and not awaiting EOI, it is serviced again.
- R8: Each level pin counts back-to-back EOI redeliveries. The redelivery that would bring the count to `STORM_LIMIT` is not made: the counter returns to 0 and the shared delay timer starts.
- R9: An EOI that finds a matching level pin masked or no longer pending resets that pin's storm counter to 0.
- R10: When the delay timer expires after `DEFER_CYCLES` clock cycles, every level pin that is pending, unmasked and not awaiting EOI is serviced.
- R11: When several pins are eligible, requests leave one at a time, lowest pin index first.
- R12: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and all request fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | NPINS | Input line levels |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin p at bits p*VEC_W upward |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination, pin p at bits p*DEST_W upward |
| cfg_note_valid | input | 1 | Strobe: a pin's configuration entry was written |
| cfg_note_pin | input | PIN_W | Pin index of the rewritten entry |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_pin | output | PIN_W | Requesting pin index |
| req_vector | output | VEC_W | Vector of the requesting pin |
| req_dest | output | DEST_W | Destination of the requesting pin |
| req_level | output | 1 | Trigger mode of the requesting pin |

## Verification
The bench runs a 4-pin instance with a storm limit of 3 and a 16-cycle delay. This keeps the throttle reachable in a few EOIs. It sweeps every pin in edge mode and then uses mixed edge and level pins for the rest.

It looks for these failure modes:
- An edge pin that is delivered twice would show that coalescing is missing.
- A level pin that fires again before its EOI would show that remote-acknowledge gating is broken.
- A line that pulses during back-pressure and is still delivered would show the pending bit being latched instead of cleared.
- An unmask notice that does nothing would strand a level interrupt.
- A storm counter that is not reset on a masked or idle EOI would throttle too early.
- A timer expiry that serves only the throttled pin would leave other waiting level pins stuck.

It also checks that the priority order holds after back-pressure and that a shared vector redelivers every pin that uses it.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  // Width of an index into n items, never less than one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    // Walk from the top so the lowest requesting index wins last.
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IW'(i);
        onehot_o = N'(1) << i;
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_defer_timer.sv
module irq_defer_timer #(
  parameter int DEFER_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = $clog2(DEFER_CYCLES + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign expire_o = run_q && (cnt_q == CW'(DEFER_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && (!run_q || expire_o)) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell #(
  parameter int STORM_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic mask_i,
  input  logic level_i,
  input  logic eoi_hit_i,
  input  logic note_i,
  input  logic expire_i,
  input  logic load_i,
  output logic pend_o,
  output logic rirr_o,
  output logic defer_o
);
  localparam int SW = $clog2(STORM_LIMIT + 1);

  logic          irr_q, rirr_q, pend_q;
  logic [SW-1:0] cnt_q;
  logic          irr_n, rirr_n, pend_n;
  logic [SW-1:0] cnt_n;
  logic          rise, lvl_eoi, redo_eoi, redo_note, redo_exp, elig;

  always_comb begin
    rise    = line_i & ~irr_q;
    irr_n   = line_i;
    lvl_eoi = eoi_hit_i & level_i;

    // Remote-acknowledge: a load of a level pin takes precedence.
    rirr_n = rirr_q;
    if (lvl_eoi || (note_i && !level_i)) rirr_n = 1'b0;
    if (load_i && level_i)               rirr_n = 1'b1;

    // Back-to-back EOI redelivery counter.
    cnt_n    = cnt_q;
    redo_eoi = 1'b0;
    defer_o  = 1'b0;
    if (lvl_eoi) begin
      if (!mask_i && irr_q) begin
        if (cnt_q == SW'(STORM_LIMIT - 1)) begin
          cnt_n   = '0;
          defer_o = 1'b1;
        end else begin
          cnt_n    = cnt_q + SW'(1);
          redo_eoi = 1'b1;
        end
      end else begin
        cnt_n = '0;
      end
    end

    redo_note = note_i & level_i & irr_q & ~mask_i & ~rirr_q;
    redo_exp  = expire_i & level_i & irr_q & ~rirr_q;

    elig   = ~mask_i & ~(level_i & rirr_n) & (~level_i | irr_n);
    pend_n = ((pend_q & ~load_i) | rise | redo_eoi | redo_note | redo_exp) & elig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      irr_q  <= irr_n;
      rirr_q <= rirr_n;
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
endmodule

// File: rtl/irq_pin_svc.sv
module irq_pin_svc #(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2500000,
  localparam int PIN_W       = irq_svc_pkg::idx_w(NPINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          line_lvl,
  input  logic [NPINS-1:0]          cfg_mask,
  input  logic [NPINS-1:0]          cfg_level,
  input  logic [NPINS*VEC_W-1:0]    cfg_vector,
  input  logic [NPINS*DEST_W-1:0]   cfg_dest,
  input  logic                      cfg_note_valid,
  input  logic [PIN_W-1:0]          cfg_note_pin,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [PIN_W-1:0]          req_pin,
  output logic [VEC_W-1:0]          req_vector,
  output logic [DEST_W-1:0]         req_dest,
  output logic                      req_level
);
  import irq_svc_pkg::*;

  logic [NPINS-1:0] pend_vec, rirr_vec, defer_vec, load_vec;
  logic [NPINS-1:0] pick_onehot;
  logic [PIN_W-1:0] pick_idx;
  logic             pick_any, load, expire;

  irq_prio_pick #(.N(NPINS), .IW(PIN_W)) u_pick (
    .req_i    (pend_vec),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .onehot_o (pick_onehot)
  );

  assign load     = pick_any && (!req_valid || req_ready);
  assign load_vec = load ? pick_onehot : '0;

  irq_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (|defer_vec),
    .expire_o (expire)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic eoi_hit, note_hit;
    assign eoi_hit  = eoi_valid && (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
    assign note_hit = cfg_note_valid && (cfg_note_pin == PIN_W'(g));

    irq_pin_cell #(.STORM_LIMIT(STORM_LIMIT)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_lvl[g]),
      .mask_i    (cfg_mask[g]),
      .level_i   (cfg_level[g]),
      .eoi_hit_i (eoi_hit),
      .note_i    (note_hit),
      .expire_i  (expire),
      .load_i    (load_vec[g]),
      .pend_o    (pend_vec[g]),
      .rirr_o    (rirr_vec[g]),
      .defer_o   (defer_vec[g])
    );
  end

  // One-deep request slot; holds its fields until accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_pin    <= '0;
      req_vector <= '0;
      req_dest   <= '0;
      req_level  <= TRIG_EDGE;
    end else if (load) begin
      req_valid  <= 1'b1;
      req_pin    <= pick_idx;
      req_vector <= cfg_vector[pick_idx*VEC_W +: VEC_W];
      req_dest   <= cfg_dest[pick_idx*DEST_W +: DEST_W];
      req_level  <= cfg_level[pick_idx];
    end else if (req_ready) begin
      req_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pin_svc_chk.sv
module irq_pin_svc_chk #(
  parameter int NPINS  = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  parameter int PIN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PIN_W-1:0]  req_pin,
  input logic [VEC_W-1:0]  req_vector,
  input logic [DEST_W-1:0] req_dest,
  input logic              load,
  input logic [PIN_W-1:0]  pick_idx,
  input logic [NPINS-1:0]  pend_vec,
  input logic [NPINS-1:0]  rirr_vec,
  input logic [NPINS-1:0]  cfg_level
);
  // R1: reset empties the request slot
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !req_valid);

  // R12: back-pressure holds the request
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_pin)
      && $stable(req_vector) && $stable(req_dest));

  // R5: a loaded level pin is awaiting EOI afterwards
  p_rirr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load && cfg_level[pick_idx] |=> rirr_vec[$past(pick_idx)]);

  // R11: the loaded pin was pending and no lower pin was
  p_loaded_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> pend_vec[pick_idx]);
  p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((pend_vec & ((NPINS'(1) << pick_idx) - NPINS'(1))) == '0));
endmodule

bind irq_pin_svc irq_pin_svc_chk #(
  .NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .PIN_W(PIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pin(req_pin), .req_vector(req_vector), .req_dest(req_dest),
  .load(load), .pick_idx(pick_idx), .pend_vec(pend_vec),
  .rirr_vec(rirr_vec), .cfg_level(cfg_level)
);

// File: tb/irq_pin_svc_tb.sv
module irq_pin_svc_tb;
  localparam int NP = 4;
  localparam int VW = 4;
  localparam int DW = 4;
  localparam int PW = 2;
  localparam int LIM = 3;
  localparam int DLY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] line = '0, mask = '1, level = '0;
  logic [NP*VW-1:0] cfg_vector;
  logic [NP*DW-1:0] cfg_dest;
  logic note_v = 1'b0;
  logic [PW-1:0] note_p = '0;
  logic eoi_v = 1'b0;
  logic [VW-1:0] eoi_vec = '0;
  logic req_valid, req_ready, req_level;
  logic [PW-1:0] req_pin;
  logic [VW-1:0] req_vector;
  logic [DW-1:0] req_dest;
  int bvec[NP];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cfg_vector[p*VW +: VW] = VW'(bvec[p]);
      cfg_dest[p*DW +: DW]   = DW'(15 - p);
    end
  end

  irq_pin_svc #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW),
                .STORM_LIMIT(LIM), .DEFER_CYCLES(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_lvl(line), .cfg_mask(mask),
    .cfg_level(level), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
    .cfg_note_valid(note_v), .cfg_note_pin(note_p),
    .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
    .req_valid(req_valid), .req_ready(req_ready), .req_pin(req_pin),
    .req_vector(req_vector), .req_dest(req_dest), .req_level(req_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_req(input int pin, input string tag, input int maxc);
    int got, fields, want;
    got = -1;
    fields = 0;
    for (int i = 0; i < maxc && got < 0; i++) begin
      if (req_valid) begin
        got = int'(req_pin);
        fields = int'({req_vector, req_dest, req_level});
      end
      @(negedge clk);
    end
    chk(got == pin, {tag, " pin"}, got, pin);
    want = (bvec[pin] << (DW + 1)) | ((15 - pin) << 1) | int'(level[pin]);
    if (got == pin) chk(fields == want, {tag, " fields"}, fields, want);
  endtask

  task automatic expect_none(input int n, input string tag);
    int seen;
    seen = 0;
    repeat (n) begin
      if (req_valid) seen++;
      @(negedge clk);
    end
    chk(seen == 0, {tag, " no request"}, seen, 0);
  endtask

  task automatic eoi(input int v);
    eoi_v = 1'b1;
    eoi_vec = VW'(v);
    @(negedge clk);
    eoi_v = 1'b0;
  endtask

  task automatic note(input int p);
    note_v = 1'b1;
    note_p = PW'(p);
    @(negedge clk);
    note_v = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) bvec[p] = p + 5;
    req_ready = 1'b1;
    step(3);
    chk(req_valid == 1'b0, "R1 during reset", int'(req_valid), 0);
    rst_n = 1'b1;
    step(3);
    chk(req_valid == 1'b0, "R1 after reset", int'(req_valid), 0);

    // R2: every pin as edge, one request then coalescing
    mask = '0;
    for (int p = 0; p < NP; p++) begin
      line[p] = 1'b1;
      expect_req(p, "R2 edge", 6);
      expect_none(8, "R2 coalesce");
      line[p] = 1'b0;
      step(2);
    end

    // R4 masked edge pin; R7 unmask of an edge pin gives nothing
    mask[1] = 1'b1;
    line[1] = 1'b1;
    expect_none(8, "R4 masked");
    mask[1] = 1'b0;
    note(1);
    expect_none(8, "R7 edge unmask");
    line[1] = 1'b0;
    step(2);

    // R5/R6 level pin 2
    level[2] = 1'b1;
    line[2] = 1'b1;
    expect_req(2, "R5 level", 6);
    line[2] = 1'b0;
    step(2);
    line[2] = 1'b1;
    expect_none(8, "R5 awaiting EOI");
    eoi(12);
    expect_none(6, "R6 other vector");
    eoi(bvec[0]);
    expect_none(6, "R6 edge vector");
    eoi(bvec[2]);
    expect_req(2, "R6 redeliver", 6);
    line[2] = 1'b0;
    step(2);
    eoi(bvec[2]);
    expect_none(8, "R6 not pending");

    // R3: level pulse during back-pressure is dropped
    req_ready = 1'b0;
    line[0] = 1'b1;
    step(3);
    line[2] = 1'b1;
    step(1);
    line[2] = 1'b0;
    step(3);
    req_ready = 1'b1;
    expect_req(0, "R3 slot", 4);
    expect_none(8, "R3 dropped pulse");
    line[0] = 1'b0;
    step(2);

    // R7 unmask and trigger-change notices on level pin 3
    mask[3] = 1'b1;
    level[3] = 1'b1;
    line[3] = 1'b1;
    expect_none(6, "R4 masked level");
    mask[3] = 1'b0;
    note(3);
    expect_req(3, "R7 unmask", 6);
    level[3] = 1'b0;
    note(3);
    level[3] = 1'b1;
    note(3);
    expect_req(3, "R7 edge clears ack", 6);
    line[3] = 1'b0;
    step(2);
    eoi(bvec[3]);
    step(2);

    // R11/R12 priority after back-pressure
    req_ready = 1'b0;
    line = '1;
    step(4);
    chk(req_valid && req_pin == 0, "R12 held", int'(req_pin), 0);
    step(3);
    chk(req_valid && req_pin == 0, "R12 still held", int'(req_pin), 0);
    req_ready = 1'b1;
    for (int p = 0; p < NP; p++) expect_req(p, "R11 order", 4);
    expect_none(6, "R11 drained");
    line = '0;
    step(2);
    eoi(bvec[2]);
    eoi(bvec[3]);
    step(2);

    // R8 storm throttle on pin 2
    line[2] = 1'b1;
    expect_req(2, "R8 first", 6);
    eoi(bvec[2]);
    expect_req(2, "R8 redeliver 1", 6);
    eoi(bvec[2]);
    expect_req(2, "R8 redeliver 2", 6);
    eoi(bvec[2]);
    expect_none(12, "R8 deferred");
    expect_req(2, "R10 expiry", 8);
    eoi(bvec[2]);
    expect_req(2, "R8 counter restarted", 6);

    // R10 expiry also serves another waiting level pin
    mask[3] = 1'b1;
    line[3] = 1'b1;
    step(3);
    mask[3] = 1'b0;
    expect_none(6, "R4 refused not queued");
    eoi(bvec[2]);
    expect_req(2, "R8 redeliver", 6);
    eoi(bvec[2]);
    expect_none(12, "R8 deferred again");
    expect_req(2, "R10 expiry pin2", 8);
    expect_req(3, "R10 expiry pin3", 4);

    // R9 masked EOI clears the counter
    eoi(bvec[2]);
    expect_req(2, "R9 count 1", 6);
    mask[2] = 1'b1;
    eoi(bvec[2]);
    expect_none(6, "R9 masked EOI");
    mask[2] = 1'b0;
    note(2);
    expect_req(2, "R7 unmask redeliver", 6);
    eoi(bvec[2]);
    expect_req(2, "R9 after clear 1", 6);
    eoi(bvec[2]);
    expect_req(2, "R9 after clear 2", 6);

    // R6 shared vector; edge pin ignores the EOI
    line[2] = 1'b0;
    step(2);
    eoi(bvec[2]);
    line[2] = 1'b1;
    expect_req(2, "R6 rearm", 6);
    line[0] = 1'b1;
    expect_req(0, "R2 edge again", 6);
    bvec[3] = bvec[2];
    step(1);
    eoi(bvec[2]);
    expect_req(2, "R6 shared pin2", 6);
    expect_req(3, "R6 shared pin3", 4);
    expect_none(8, "R6 edge ignores EOI");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule